// File: doc/BRIEF.md
# 100BASE-TX Receive Code-Group Decoder

This block takes 5-bit code-groups from the line side of a 100 Mb/s twisted-pair receiver and turns them into the nibble-wide receive interface a MAC expects. The code-groups must already be aligned, descrambled and recovered from the line. While the line is idle, the block searches for the start-of-stream pair. After the pair it marks a frame with a data-valid flag and converts each data code-group back to its 4-bit value. It raises an error flag for code-groups that are not allowed inside a frame. It closes the frame on the end-of-stream pair.

The block holds each code-group for one step before acting on it. This lets it see the code-group that follows. A start pair can then be told apart from a false carrier before any nibble leaves the block, and a terminating code-group can be checked for its partner. The line side has no back-pressure. `cg_valid` marks each cycle that carries a new code-group, and the receive side can never stall the line. The output side is a plain strobe, `rx_stb`, with no ready signal. In each cycle with `rx_stb` high, the consumer must take `rxd`, `rx_dv` and `rx_er`. In cycles without a new code-group the outputs hold their values.

Top module: `pcs_rx_decoder`

## Requirements
- R1: After reset, `rxd` is 0000 and `rx_dv`, `rx_er` and `rx_stb` are all low.
- R2: Outside a frame, the Idle code-group 11111 produces `rx_dv`=0, `rx_er`=0 and `rxd`=0000.
- R3: J (11000) followed directly by K (10001) opens a frame. Both produce `rxd`=0101 with `rx_dv`=1 and `rx_er`=0, and `rx_dv` rises on the nibble for J.
- R4: Inside a frame, data code-groups decode as follows, with `rx_dv`=1 and `rx_er`=0:
  - 11110→0, 01001→1, 10100→2, 10101→3
  - 01010→4, 01011→5, 01110→6, 01111→7
  - 10010→8, 10011→9, 10110→A, 10111→B
  - 11010→C, 11011→D, 11100→E, 11101→F
- R5: T (01101) followed by R (00111) closes a frame. The nibble for T has `rx_dv`=0 and `rx_er`=0, the R is consumed with `rx_dv`=0 and `rx_er`=0, and decoding then returns to the idle search.
- R6: A T that is not followed by R produces `rx_dv`=0 and `rx_er`=1 for the T nibble. The next code-group is handled as idle-side input.
- R7: Inside a frame, any code-group other than the 16 data codes, T and Idle gives `rx_dv`=1, `rx_er`=1 and `rxd`=0000. This includes J, K, R, 00100 and every other unused value. `rx_er` then stays high, with `rxd`=0000, for every later nibble of that frame while `rx_dv` is high.
- R8: A J that is not directly followed by K is a false carrier. It produces one nibble with `rx_dv`=0, `rx_er`=1 and `rxd`=1110, and the search continues with the next code-group.
- R9: An Idle code-group inside a frame ends the frame early. Its nibble has `rx_dv`=0 and `rx_er`=1.
- R10: The nibble for code-group n appears on the clock edge that accepts code-group n+1. `rx_stb` is high in the cycle after each edge with `cg_valid` high and low otherwise. Edges without `cg_valid` leave `rxd`, `rx_dv` and `rx_er` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, one code-group per enabled edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cg_valid | input | 1 | A new aligned code-group is on `cg_data` |
| cg_data | input | 5 | Aligned 5-bit code-group |
| rxd | output | 4 | Decoded nibble |
| rx_dv | output | 1 | Nibble belongs to a frame |
| rx_er | output | 1 | Error or false-carrier indication |
| rx_stb | output | 1 | Output nibble updated this cycle |

## Verification
A wrong state or a lost error memory has a visible effect at the ports. It shows one step later, on the nibble of the code-group after the event. A missed start pair leaves `rx_dv` low over the whole frame. A stuck frame state keeps `rx_dv` high past T/R. A lost error memory lets `rx_er` drop back while `rx_dv` is still high. Sweeping every one of the 32 code values into the middle of a frame exposes any decode or validity-class error on the next `rx_stb`.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  localparam logic [CG_W-1:0] CODE_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CODE_J    = 5'b11000;
  localparam logic [CG_W-1:0] CODE_K    = 5'b10001;
  localparam logic [CG_W-1:0] CODE_T    = 5'b01101;
  localparam logic [CG_W-1:0] CODE_R    = 5'b00111;

  typedef enum logic [2:0] {
    KIND_DATA, KIND_IDLE, KIND_J, KIND_K, KIND_T, KIND_R, KIND_BAD
  } cg_kind_t;

  typedef enum logic [1:0] {
    ST_HUNT, ST_SSD2, ST_FRAME, ST_SKIP_R
  } rx_state_t;

  typedef struct packed {
    logic             dv;
    logic             er;
    logic [NIB_W-1:0] nib;
  } mii_word_t;
endpackage

// File: rtl/pcs_cg_classify.sv
module pcs_cg_classify
  import pcs_rx_pkg::*;
(
  input  logic [CG_W-1:0]  cg,
  output cg_kind_t         kind,
  output logic [NIB_W-1:0] nib
);
  always_comb begin
    kind = KIND_DATA;
    nib  = '0;
    unique case (cg)
      5'b11110: nib = 4'h0;
      5'b01001: nib = 4'h1;
      5'b10100: nib = 4'h2;
      5'b10101: nib = 4'h3;
      5'b01010: nib = 4'h4;
      5'b01011: nib = 4'h5;
      5'b01110: nib = 4'h6;
      5'b01111: nib = 4'h7;
      5'b10010: nib = 4'h8;
      5'b10011: nib = 4'h9;
      5'b10110: nib = 4'hA;
      5'b10111: nib = 4'hB;
      5'b11010: nib = 4'hC;
      5'b11011: nib = 4'hD;
      5'b11100: nib = 4'hE;
      5'b11101: nib = 4'hF;
      CODE_IDLE: kind = KIND_IDLE;
      CODE_J:    kind = KIND_J;
      CODE_K:    kind = KIND_K;
      CODE_T:    kind = KIND_T;
      CODE_R:    kind = KIND_R;
      default:   kind = KIND_BAD;
    endcase
  end
endmodule

// File: rtl/pcs_rx_ctrl.sv
module pcs_rx_ctrl
  import pcs_rx_pkg::*;
#(
  parameter logic [NIB_W-1:0] SSD_NIB = 4'b0101,
  parameter logic [NIB_W-1:0] FC_NIB  = 4'b1110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  cg_kind_t         held_kind,
  input  logic [NIB_W-1:0] held_nib,
  input  logic [CG_W-1:0]  next_cg,
  output mii_word_t        word
);
  rx_state_t state_q, state_d;
  logic      spoil_q, spoil_d;
  mii_word_t word_d;

  always_comb begin
    state_d = state_q;
    spoil_d = spoil_q;
    word_d  = '{dv: 1'b0, er: 1'b0, nib: '0};
    unique case (state_q)
      ST_HUNT: begin
        if (held_kind == KIND_J) begin
          if (next_cg == CODE_K) begin
            word_d  = '{dv: 1'b1, er: 1'b0, nib: SSD_NIB};
            state_d = ST_SSD2;
          end else begin
            word_d  = '{dv: 1'b0, er: 1'b1, nib: FC_NIB};
          end
        end
      end
      ST_SSD2: begin
        word_d  = '{dv: 1'b1, er: 1'b0, nib: SSD_NIB};
        spoil_d = 1'b0;
        state_d = ST_FRAME;
      end
      ST_FRAME: begin
        unique case (held_kind)
          KIND_DATA: word_d = '{dv: 1'b1, er: spoil_q, nib: spoil_q ? '0 : held_nib};
          KIND_T: begin
            word_d.er = (next_cg != CODE_R);
            state_d   = (next_cg == CODE_R) ? ST_SKIP_R : ST_HUNT;
            spoil_d   = 1'b0;
          end
          KIND_IDLE: begin
            word_d.er = 1'b1;
            state_d   = ST_HUNT;
            spoil_d   = 1'b0;
          end
          default: begin
            word_d  = '{dv: 1'b1, er: 1'b1, nib: '0};
            spoil_d = 1'b1;
          end
        endcase
      end
      ST_SKIP_R: state_d = ST_HUNT;
      default:   state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      spoil_q <= 1'b0;
      word    <= '{dv: 1'b0, er: 1'b0, nib: '0};
    end else if (adv) begin
      state_q <= state_d;
      spoil_q <= spoil_d;
      word    <= word_d;
    end
  end
endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
  import pcs_rx_pkg::*;
#(
  parameter logic [NIB_W-1:0] SSD_NIB = 4'b0101,
  parameter logic [NIB_W-1:0] FC_NIB  = 4'b1110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cg_valid,
  input  logic [CG_W-1:0]  cg_data,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             rx_stb
);
  logic [CG_W-1:0]  held_q;
  cg_kind_t         held_kind;
  logic [NIB_W-1:0] held_nib;
  mii_word_t        word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= CODE_IDLE;
      rx_stb <= 1'b0;
    end else begin
      rx_stb <= cg_valid;
      if (cg_valid) held_q <= cg_data;
    end
  end

  pcs_cg_classify u_cls (
    .cg   (held_q),
    .kind (held_kind),
    .nib  (held_nib)
  );

  pcs_rx_ctrl #(.SSD_NIB(SSD_NIB), .FC_NIB(FC_NIB)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (cg_valid),
    .held_kind (held_kind),
    .held_nib  (held_nib),
    .next_cg   (cg_data),
    .word      (word)
  );

  assign rxd   = word.nib;
  assign rx_dv = word.dv;
  assign rx_er = word.er;
endmodule

// File: rtl/pcs_rx_checker.sv
module pcs_rx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cg_valid,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       rx_stb
);
  AST_STB_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cg_valid |=> rx_stb); // R10
  AST_STB_OFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_valid |=> !rx_stb); // R10
  AST_HOLD_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_valid |=> ($stable(rxd) && $stable(rx_dv) && $stable(rx_er))); // R10
  AST_ERR_NIB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && rx_er) |-> (rxd == 4'b0000)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && rx_er) |=> (!rx_dv || rx_er)); // R7
  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_dv && !rx_er) |-> (rxd == 4'b0000)); // R2
  AST_CARRIER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_dv && rx_er && rxd != 4'b0000) |-> (rxd == 4'b1110)); // R8
endmodule

bind pcs_rx_decoder pcs_rx_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cg_valid (cg_valid),
  .rxd      (rxd),
  .rx_dv    (rx_dv),
  .rx_er    (rx_er),
  .rx_stb   (rx_stb)
);

// File: tb/sim_pcs_rx_decoder.sv
module sim_pcs_rx_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cg_valid = 1'b0;
  logic [4:0] cg_data = 5'b11111;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, rx_stb;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  localparam logic [4:0] I_ = 5'b11111, J_ = 5'b11000, K_ = 5'b10001,
                         T_ = 5'b01101, R_ = 5'b00111;

  logic [4:0] stim [128];
  logic [5:0] expv [128];
  int         n_st;

  pcs_rx_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cg_valid(cg_valid), .cg_data(cg_data),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .rx_stb(rx_stb)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [4:0] enc(input logic [3:0] v);
    case (v)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  function automatic int dec(input logic [4:0] c);
    dec = -1;
    for (int v = 0; v < 16; v++) if (enc(4'(v)) == c) dec = v;
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp_w);
    n_chk++;
    if (act !== exp_w) begin
      n_bad++;
      $display("FAIL %s: dv/er/rxd actual %b/%b/%b expected %b/%b/%b", tag,
               act[5], act[4], act[3:0], exp_w[5], exp_w[4], exp_w[3:0]);
    end
  endtask

  task automatic add(input logic [4:0] c, input logic dv, input logic er, input logic [3:0] nb);
    stim[n_st] = c; expv[n_st] = {dv, er, nb}; n_st++;
  endtask

  task automatic run(input string tag);
    for (int i = 0; i < n_st + 2; i++) begin
      @(negedge clk);
      if (i >= 2) check(tag, {rx_dv, rx_er, rxd}, expv[i-2]);
      cg_valid = 1'b1;
      cg_data  = (i < n_st) ? stim[i] : I_;
    end
    n_st = 0;
  endtask

  initial begin
    n_st = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", {rx_dv, rx_er, rxd}, 6'b0);
    n_chk++; if (rx_stb !== 1'b0) begin n_bad++; $display("FAIL R1 stb actual %b expected 0", rx_stb); end
    rst_n = 1'b1;

    // R2: idle line
    repeat (6) add(I_, 0, 0, 4'h0);
    run("R2 idle");

    // R3 R4 R5: full data sweep in one frame
    add(I_, 0, 0, 0); add(J_, 1, 0, 4'h5); add(K_, 1, 0, 4'h5);
    for (int v = 0; v < 16; v++) add(enc(4'(v)), 1, 0, 4'(v));
    add(T_, 0, 0, 0); add(R_, 0, 0, 0); add(I_, 0, 0, 0);
    run("R3/R4/R5 frame");

    // R7 R4: every code value injected mid-frame
    for (int c = 0; c < 32; c++) begin
      logic [4:0] cc = 5'(c);
      if (cc == T_ || cc == I_) continue;
      add(I_, 0, 0, 0); add(J_, 1, 0, 4'h5); add(K_, 1, 0, 4'h5);
      add(enc(4'h5), 1, 0, 4'h5);
      if (dec(cc) >= 0) begin
        add(cc, 1, 0, 4'(dec(cc))); add(enc(4'h6), 1, 0, 4'h6);
      end else begin
        add(cc, 1, 1, 0); add(enc(4'h6), 1, 1, 0);
      end
      add(T_, 0, 0, 0); add(R_, 0, 0, 0); add(I_, 0, 0, 0);
      run("R7 code sweep");
    end

    // R6: T without R
    add(I_, 0, 0, 0); add(J_, 1, 0, 4'h5); add(K_, 1, 0, 4'h5); add(enc(4'h3), 1, 0, 4'h3);
    add(T_, 0, 1, 0); add(I_, 0, 0, 0); add(I_, 0, 0, 0);
    run("R6 T no R");

    // R8: false carrier, then J J K recovers
    add(I_, 0, 0, 0); add(J_, 0, 1, 4'hE); add(I_, 0, 0, 0);
    add(J_, 0, 1, 4'hE); add(J_, 1, 0, 4'h5); add(K_, 1, 0, 4'h5);
    add(enc(4'h1), 1, 0, 4'h1); add(T_, 0, 0, 0); add(R_, 0, 0, 0); add(I_, 0, 0, 0);
    run("R8 false carrier");

    // R9: idle inside frame
    add(I_, 0, 0, 0); add(J_, 1, 0, 4'h5); add(K_, 1, 0, 4'h5); add(enc(4'h2), 1, 0, 4'h2);
    add(I_, 0, 1, 0); add(I_, 0, 0, 0); add(I_, 0, 0, 0);
    run("R9 idle in frame");

    // R10: valid gaps hold outputs and drop strobe
    @(negedge clk); cg_valid = 1; cg_data = J_;
    @(negedge clk); cg_data = K_;
    @(negedge clk); cg_data = enc(4'h7);
    @(negedge clk); check("R10 pre-gap", {rx_dv, rx_er, rxd}, 6'b10_0101); cg_valid = 0; cg_data = 5'b00000;
    for (int g = 0; g < 2; g++) begin
      @(negedge clk);
      check("R10 gap hold", {rx_dv, rx_er, rxd}, 6'b10_0101);
      n_chk++; if (rx_stb !== 1'b0) begin n_bad++; $display("FAIL R10 stb actual %b expected 0", rx_stb); end
    end
    cg_valid = 1; cg_data = enc(4'h8);
    @(negedge clk); check("R10 after gap", {rx_dv, rx_er, rxd}, 6'b10_0111);
    n_chk++; if (rx_stb !== 1'b1) begin n_bad++; $display("FAIL R10 stb actual %b expected 1", rx_stb); end
    cg_data = T_;
    @(negedge clk); check("R10 data", {rx_dv, rx_er, rxd}, 6'b10_1000); cg_data = R_;
    @(negedge clk); check("R10 end", {rx_dv, rx_er, rxd}, 6'b00_0000); cg_data = I_;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule